// File: doc/BRIEF.md
# Power-of-Two Sample Decimator

This block thins an ADC sample stream that arrives on every cycle of a single fast clock. It keeps one sample out of every 2^N. N is a small exponent taken from a register in the same clock domain, and zero means every sample passes. The retained sample comes out on a registered bus together with a one-cycle valid strobe. The strobe is meant to drive the write enable of a downstream FIFO. No clock is divided or gated: the full sample clock drives every register, and only the strobe marks which cycles carry data.

When the effective exponent changes, the internal sample counter restarts. The first sample taken under the new exponent is always emitted, and from then on spacing follows the new ratio with no stray partial interval. An exponent above the supported maximum is clamped to that maximum.

Top module: `pow2_decimator`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `smp_vld` = 0 and `smp_out` = 0; the exponent in use after reset is taken as 0.
- R2: With an effective exponent of 0, every input sample is emitted: `smp_vld` is 1 on every cycle and `smp_out` equals the `smp_in` sampled at the previous edge.
- R3: With an effective exponent N, samples are counted as index 0, 1, 2, ... from the first edge after reset or after an exponent change; `smp_vld` is 1 exactly for indices that are multiples of 2^N.
- R4: When `smp_vld` is 1, `smp_out` holds the `smp_in` value captured at the same edge, one cycle of latency.
- R5: When `smp_vld` is 0, `smp_out` keeps its previous value.
- R6: An edge at which the effective exponent differs from the one used at the previous edge restarts the count at index 0, so that sample is emitted.
- R7: An `exp_sel` value above MAX_EXP acts as MAX_EXP; moving between two values that both clamp to MAX_EXP is not a change and causes no restart.
- R8: With a nonzero exponent, `smp_vld` is never high on two consecutive cycles unless the second one comes from a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate sample clock |
| rst | input | 1 | Synchronous active-high reset |
| exp_sel | input | EXP_W | Decimation exponent N, ratio 2^N, from a local shadow register |
| smp_in | input | DATA_W | Input sample, one per clock |
| smp_out | output | DATA_W | Retained sample, registered |
| smp_vld | output | 1 | One-cycle strobe marking a retained sample |

## Verification
A corrupt counter or stale exponent register would show on the strobe at once: the spacing between `smp_vld` pulses would drift from 2^N, or the pulse expected on the first edge after an exponent change would be missing. A wrong data capture would show on `smp_out` at the first strobe, as a value other than the sample fed one cycle earlier, or as a change between strobes. The bench sweeps every exponent code, including the clamped ones, and compares each cycle's strobe and data against an index-based expectation, so any fault is seen within one decimation period.

// File: rtl/pow2_decimator.sv
module pow2_decimator #(
  parameter int DATA_W  = 14,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXP_W-1:0]  exp_sel,
  input  logic [DATA_W-1:0] smp_in,
  output logic [DATA_W-1:0] smp_out,
  output logic              smp_vld
);

  localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [EXP_W-1:0] exp_eff;
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_now;
  logic [CNT_W-1:0] low_mask;
  logic             restart;
  logic             take;

  assign exp_eff  = (32'(exp_sel) > MAX_EXP) ? EXP_W'(MAX_EXP) : exp_sel;
  assign restart  = exp_eff != exp_q;
  assign cnt_now  = restart ? '0 : cnt_q;
  assign low_mask = ~({CNT_W{1'b1}} << exp_eff);
  assign take     = (cnt_now & low_mask) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      exp_q   <= '0;
      smp_vld <= 1'b0;
      smp_out <= '0;
    end else begin
      cnt_q   <= cnt_now + 1'b1;
      exp_q   <= exp_eff;
      smp_vld <= take;
      if (take) smp_out <= smp_in;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!smp_vld && smp_out == '0));

  a_r2_pass_all: assert property (@(posedge clk) disable iff (rst)
    (exp_eff == '0) |=> (smp_vld && smp_out == $past(smp_in)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |-> $stable(smp_out));

  a_r6_restart_emits: assert property (@(posedge clk) disable iff (rst)
    restart |=> smp_vld);

  a_r7_clamp_range: assert property (@(posedge clk) disable iff (rst)
    32'(exp_q) <= MAX_EXP);

  a_r8_spacing: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $past(smp_vld)) |-> (exp_q == '0 || exp_q != $past(exp_q)));

endmodule

// File: tb/sim_pow2_decimator.sv
module sim_pow2_decimator;
  localparam int DW = 8;
  localparam int EW = 4;
  localparam int MX = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [EW-1:0] exp_sel = '0;
  logic [DW-1:0] smp_in = '0;
  logic [DW-1:0] smp_out;
  logic          smp_vld;

  int checks = 0;
  int errors = 0;
  int m_prev = 0;
  int m_idx  = 0;
  logic [DW-1:0] m_out = '0;
  bit done = 0;

  always #5 clk = ~clk;

  pow2_decimator #(.DATA_W(DW), .EXP_W(EW), .MAX_EXP(MX)) u0 (
    .clk(clk), .rst(rst), .exp_sel(exp_sel),
    .smp_in(smp_in), .smp_out(smp_out), .smp_vld(smp_vld)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // one clock: inputs held from negedge, model updated, outputs checked after the edge
  task automatic step(input logic [EW-1:0] e, input logic [DW-1:0] d);
    int ee;
    bit restarted;
    bit exp_v;
    string rq;
    @(negedge clk);
    exp_sel = e;
    smp_in  = d;
    @(posedge clk);
    ee = (int'(e) > MX) ? MX : int'(e);
    restarted = 0;
    if (rst) begin
      m_prev = 0; m_idx = 0; m_out = '0; exp_v = 0;
    end else begin
      if (ee != m_prev) begin m_idx = 0; restarted = 1; end
      exp_v = (m_idx % (1 << ee)) == 0;
      if (exp_v) m_out = d;
      m_idx++;
      m_prev = ee;
    end
    #2;
    if (rst) rq = "R1";
    else if (restarted) rq = "R6";
    else if (int'(e) > MX) rq = "R7";
    else if (ee == 0) rq = "R2";
    else rq = "R3";
    chk({rq, " vld"}, int'(smp_vld), int'(exp_v));
    chk(exp_v ? "R4 data" : "R5 hold", int'(smp_out), int'(m_out));
    if (!rst && ee != 0 && !restarted && exp_v)
      chk("R8 gap", int'(smp_vld), 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s;
    s = 8'h11;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin step(4'd3, s); s = s + 8'd7; end
    rst = 1'b0;
    // full sweep of every exponent code, including the clamped ones (R7)
    for (int e = 0; e < 16; e++)
      for (int k = 0; k < 70; k++) begin step(EW'(e), s); s = s + 8'd13; end
    // clamp equivalence: 9 -> 12 both act as MX, no restart (R7)
    for (int k = 0; k < 40; k++) begin step(4'd9, s); s = s + 8'd3; end
    for (int k = 0; k < 40; k++) begin step(4'd12, s); s = s + 8'd3; end
    // mid-interval changes restart the count (R6)
    for (int k = 0; k < 5; k++) begin step(4'd4, s); s = s + 8'd5; end
    for (int k = 0; k < 9; k++) begin step(4'd2, s); s = s + 8'd5; end
    for (int k = 0; k < 3; k++) begin step(4'd1, s); s = s + 8'd5; end
    for (int k = 0; k < 20; k++) begin step(EW'(k % 3), s); s = s + 8'd9; end
    // reset in mid-stream (R1), then resume at exponent 3
    rst = 1'b1;
    for (int k = 0; k < 2; k++) begin step(4'd3, s); s = s + 8'd1; end
    rst = 1'b0;
    for (int k = 0; k < 30; k++) begin step(4'd3, s); s = s + 8'd1; end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule